// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader with Destination Steering

This block takes configuration words from a three-wire serial port (serial clock, serial data and load enable) and places them in one of two holding latches. These latches feed the reference divider and the feedback divider of a frequency synthesizer. All three serial pins are asynchronous to the system clock. They are brought into the system clock domain through a synchroniser chain, and edges are detected there. Each rising edge of the serial clock pushes one data bit into a shift register. The first bit sent is the most significant bit.

The last bit of each word is a steering bit. When load enable rises, the block looks at the most recently captured bit. If that bit is 1, the 15 bits shifted in just before it go into the reference latch: first a prescaler-select bit, then 14 reference-count bits. If that bit is 0, the 18 bits shifted in just before it go into the feedback latch. A one-cycle strobe marks each update, and the strobe belongs to the latch that was written. The load-enable pin has a pull-up on the board, so the idle state of load enable is high. A host lowers load enable, clocks in a word, and raises load enable again to commit the word.

Top module: `serial_loader_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both latches read zero and both strobes are low.
- R2: The shift register captures the data pin once on each rising edge of the serial clock, whatever the level of load enable. Changes on the data pin while the serial clock is static capture nothing.
- R3: If the last captured bit is 1 when load enable rises, the reference latch takes the 15 bits received just before that bit. The earliest of those 15 bits lands in bit 14, the prescaler-select position.
- R4: If the last captured bit is 0 when load enable rises, the feedback latch takes the 18 bits received just before that bit. The earliest of those 18 bits lands in bit 17.
- R5: A latch changes only on a rising edge of load enable. Serial clocks given while load enable stays high leave both latches unchanged.
- R6: Each transfer raises exactly one strobe, the one that belongs to the written latch, for exactly one system clock cycle. The other latch keeps its value.
- R7: Load enable is taken as high from reset onward. If load enable is already high when reset ends, no transfer takes place until load enable has gone low and risen again.
- R8: Only the most recent bits count. Extra bits sent ahead of a word are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, first bit is the MSB, steering bit last |
| ser_le_i | input | 1 | Load enable, asynchronous, idles high |
| ref_word_o | output | REF_W | Reference latch: prescaler select in the top bit, count below it |
| ref_upd_o | output | 1 | One-cycle strobe when the reference latch is written |
| fb_word_o | output | FB_W | Feedback divider latch |
| fb_upd_o | output | 1 | One-cycle strobe when the feedback latch is written |

## Verification
The bench builds the block with its default parameters: REF_W of 15, FB_W of 18 and SYNC_STAGES of 2. With these values the shift register is 19 bits long, just long enough for a feedback word. Because of that, a reference word must select its payload out of a register that is wider than the word. Words of all ones and alternating patterns reach the top bit of each latch, and a leading-junk frame checks that bits beyond the register length fall off. Two synchroniser stages keep the serial half-periods short, so many frames fit into a short run.

// File: rtl/sl_pkg.sv
// Shared types for the serial loader.
// Assumes: the steering bit is the last bit captured by the shift register.
package sl_pkg;

    typedef enum logic {
        SL_DEST_FB  = 1'b0,
        SL_DEST_REF = 1'b1
    } sl_dest_e;

    // Map the captured steering bit onto a destination.
    function automatic sl_dest_e sl_decode(input logic steer_bit);
        return steer_bit ? SL_DEST_REF : SL_DEST_FB;
    endfunction

endpackage

// File: rtl/sl_sync.sv
// Multi-bit level synchroniser for asynchronous pins.
// Assumes: each bit is an independent slow level, so skew between bits is
// harmless as long as the sender keeps setup margin on its own protocol.
module sl_sync #(
    parameter int                 WIDTH     = 3,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift pin levels through the synchroniser flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                chain[s] <= chain[s-1];
            end
            chain[0] <= async_in;
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sl_edge.sv
// Rising-edge detector on synchronised levels.
// Assumes: inputs already belong to the clk domain; the reset value models
// the idle level so no false edge appears when reset ends.
module sl_edge #(
    parameter int               WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    output logic [WIDTH-1:0] rise_out
);

    logic [WIDTH-1:0] prev_q;

    // Remember the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RESET_VAL;
        else        prev_q <= level_in;
    end

    assign rise_out = level_in & ~prev_q;

endmodule

// File: rtl/sl_shift.sv
// Serial-in shift register. The newest bit enters at index 0, so after a
// full word the first bit sent sits at the top.
// Assumes: shift_en is a single-cycle pulse per serial clock edge.
module sl_shift #(
    parameter int LEN = 19
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] sr_q
);

    // Capture one data bit per serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[LEN-2:0], din};
    end

endmodule

// File: rtl/sl_steer.sv
// Decodes the steering bit and commits the word to one of two latches,
// raising a one-cycle strobe for the latch that was written.
// Assumes: load is a single-cycle pulse; LEN covers the wider word plus one.
module sl_steer
    import sl_pkg::*;
#(
    parameter int REF_W = 15,
    parameter int FB_W  = 18,
    parameter int LEN   = FB_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN-1:0]   sr,
    output logic [REF_W-1:0] ref_word,
    output logic             ref_upd,
    output logic [FB_W-1:0]  fb_word,
    output logic             fb_upd
);

    sl_dest_e dest;

    // Pick the destination from the most recently captured bit.
    always_comb dest = sl_decode(sr[0]);

    // Commit the payload and pulse the matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_word <= '0;
            fb_word  <= '0;
            ref_upd  <= 1'b0;
            fb_upd   <= 1'b0;
        end else begin
            ref_upd <= 1'b0;
            fb_upd  <= 1'b0;
            if (load) begin
                if (dest == SL_DEST_REF) begin
                    ref_word <= sr[REF_W:1];
                    ref_upd  <= 1'b1;
                end else begin
                    fb_word <= sr[FB_W:1];
                    fb_upd  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_loader_top.sv
// Three-wire serial loader: synchronises the pins, shifts data on serial
// clock rises and steers the word to the reference or feedback latch when
// load enable rises.
// Assumes: serial data is stable around each serial clock rise for longer
// than SYNC_STAGES+1 system cycles; load enable idles high (pull-up).
module serial_loader_top #(
    parameter int REF_W       = 15,
    parameter int FB_W        = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_le_i,
    output logic [REF_W-1:0] ref_word_o,
    output logic             ref_upd_o,
    output logic [FB_W-1:0]  fb_word_o,
    output logic             fb_upd_o
);

    localparam int PAYLOAD_MAX = (FB_W > REF_W) ? FB_W : REF_W;
    localparam int SR_LEN      = PAYLOAD_MAX + 1;
    localparam int PIN_LE      = 2;
    localparam int PIN_DAT     = 1;
    localparam int PIN_CLK     = 0;

    logic [2:0]        pins_sync;
    logic [1:0]        rises;
    logic [SR_LEN-1:0] sr;

    sl_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_le_i, ser_dat_i, ser_clk_i}),
        .sync_out (pins_sync)
    );

    sl_edge #(
        .WIDTH     (2),
        .RESET_VAL (2'b10)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in ({pins_sync[PIN_LE], pins_sync[PIN_CLK]}),
        .rise_out (rises)
    );

    sl_shift #(
        .LEN (SR_LEN)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rises[0]),
        .din      (pins_sync[PIN_DAT]),
        .sr_q     (sr)
    );

    sl_steer #(
        .REF_W (REF_W),
        .FB_W  (FB_W),
        .LEN   (SR_LEN)
    ) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rises[1]),
        .sr       (sr),
        .ref_word (ref_word_o),
        .ref_upd  (ref_upd_o),
        .fb_word  (fb_word_o),
        .fb_upd   (fb_upd_o)
    );

endmodule

// File: rtl/serial_loader_chk.sv
// Property checker for serial_loader_top, attached by bind below.
// Assumes: it observes only the top-level ports.
module serial_loader_chk #(
    parameter int REF_W = 15,
    parameter int FB_W  = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REF_W-1:0] ref_word_o,
    input logic             ref_upd_o,
    input logic [FB_W-1:0]  fb_word_o,
    input logic             fb_upd_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ref_word_o == '0 && fb_word_o == '0 && !ref_upd_o && !fb_upd_o)); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_upd_o && fb_upd_o)); // R6

    AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd_o |=> !ref_upd_o); // R6

    AST_FB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_upd_o |=> !fb_upd_o); // R6

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd_o |-> $stable(ref_word_o)); // R5

    AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_upd_o |-> $stable(fb_word_o)); // R5

endmodule

bind serial_loader_top serial_loader_chk #(
    .REF_W (REF_W),
    .FB_W  (FB_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_word_o (ref_word_o),
    .ref_upd_o  (ref_upd_o),
    .fb_word_o  (fb_word_o),
    .fb_upd_o   (fb_upd_o)
);

// File: tb/test_serial_loader_top.sv
module test_serial_loader_top;

    localparam int REF_W = 15;
    localparam int FB_W  = 18;
    localparam int NVEC  = 6;

    // Vector format: bit 18 = 1 for a reference word, payload in [17:0].
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 3'b000, 15'h7FFF},
        {1'b0, 18'h3FFFF},
        {1'b1, 3'b000, 15'h4001},
        {1'b0, 18'h2AAAA},
        {1'b1, 3'b000, 15'h0008},
        {1'b0, 18'h15555}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ser_clk = 1'b0;
    logic             ser_dat = 1'b0;
    logic             ser_le = 1'b1;
    logic [REF_W-1:0] ref_word;
    logic             ref_upd;
    logic [FB_W-1:0]  fb_word;
    logic             fb_upd;

    int n_cmp = 0;
    int n_err = 0;
    int ref_cnt = 0;
    int fb_cnt = 0;
    int exp_rc = 0;
    int exp_fc = 0;
    logic [REF_W-1:0] exp_ref = '0;
    logic [FB_W-1:0]  exp_fb  = '0;

    always #2 clk = ~clk;

    serial_loader_top i_serial_loader_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_dat_i  (ser_dat),
        .ser_le_i   (ser_le),
        .ref_word_o (ref_word),
        .ref_upd_o  (ref_upd),
        .fb_word_o  (fb_word),
        .fb_upd_o   (fb_upd)
    );

    // Count strobe-high cycles, sampled away from the active edge.
    always @(negedge clk) begin
        if (ref_upd) ref_cnt++;
        if (fb_upd)  fb_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " ref"}, 32'(ref_word), 32'(exp_ref));
        check({req, " fb"},  32'(fb_word),  32'(exp_fb));
        check({req, " ref strobes"}, 32'(ref_cnt), 32'(exp_rc));
        check({req, " fb strobes"},  32'(fb_cnt),  32'(exp_fc));
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk) ser_dat = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic raise_le();
        repeat (4) @(negedge clk);
        ser_le = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // Clock a word (with optional leading junk) without touching load enable.
    task automatic shift_word(input logic is_ref, input logic [17:0] pay, input int junk);
        for (int j = 0; j < junk; j++) put_bit(j[0]);
        if (is_ref) for (int i = REF_W - 1; i >= 0; i--) put_bit(pay[i]);
        else        for (int i = FB_W - 1; i >= 0; i--)  put_bit(pay[i]);
        put_bit(is_ref);
    endtask

    task automatic send_frame(input logic is_ref, input logic [17:0] pay, input int junk);
        @(negedge clk) ser_le = 1'b0;
        shift_word(is_ref, pay, junk);
        raise_le();
        if (is_ref) begin exp_ref = pay[REF_W-1:0]; exp_rc++; end
        else        begin exp_fb  = pay;            exp_fc++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        // R1: reset state, load enable held high through reset.
        repeat (5) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");
        // R7: load enable high out of reset causes no transfer.
        repeat (20) @(negedge clk);
        check_all("R7 idle high");

        // Vector table: R3 and R4 payload placement, R6 strobes.
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][18], VEC[v][17:0], 0);
            check_all(VEC[v][18] ? "R3 R6 vector" : "R4 R6 vector");
        end

        // R3: prescaler-select bit alone lands in bit 14.
        send_frame(1'b1, 18'h04000, 0);
        check_all("R3 top bit");

        // R8: leading junk ahead of a reference and a feedback word.
        send_frame(1'b1, 18'h05A5A, 7);
        check_all("R8 ref junk");
        send_frame(1'b0, 18'h0F0F1, 5);
        check_all("R8 fb junk");

        // R5: clocks while load enable stays high change no latch.
        shift_word(1'b1, 18'h01234, 0);
        repeat (10) @(negedge clk);
        check_all("R5 le held high");

        // R2: shift register kept those bits; a fresh load enable rise commits them.
        @(negedge clk) ser_le = 1'b0;
        raise_le();
        exp_ref = 15'h1234; exp_rc++;
        check_all("R2 capture while le high");

        // R2: data toggles with static serial clock capture nothing.
        @(negedge clk) ser_le = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk) ser_dat = ~ser_dat;
        end
        raise_le();
        exp_rc++;
        check_all("R2 no clock no shift");

        // R1 and R7: mid-run reset with load enable high.
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_ref = '0; exp_fb = '0;
        repeat (20) @(negedge clk);
        check("R1 ref cleared", 32'(ref_word), 32'd0);
        check("R1 fb cleared", 32'(fb_word), 32'd0);
        check("R7 no strobe after reset", 32'(ref_cnt + fb_cnt), 32'(exp_rc + exp_fc));

        // R4 and R6: working again after reset.
        send_frame(1'b0, 18'h20001, 0);
        check_all("R4 R6 after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule